// File: doc/BRIEF.md
# Dual-Channel Match Timer

This peripheral holds two independent 16-bit up-counters. Each counter has its own clock divider, compare register and interrupt line. Software reaches every register over a simple 16-bit register bus. A write is taken on a rising clock edge while `bus_en` and `bus_we` are high. The read data is a combinational function of `bus_addr`.

One shared run register carries a single run bit per channel. When a channel is running, its divider produces one count tick every 8, 32, 128 or 512 clocks, as set by its 2-bit clock-select field. On a tick where the count already equals the compare value, the counter clears to zero instead of incrementing. On that same tick the channel raises its interrupt for exactly one clock, but only if its interrupt enable is set. A channel therefore signals once every (compare + 1) × ratio clocks.

Each channel is controlled by a two-state machine:

| State | Meaning |
|---|---|
| `CH_IDLE` | The counter and the divider phase are frozen. |
| `CH_RUN` | The divider and the counter advance. |

The machine has two transitions:

| Transition | From → To | Cause | Effect |
|---|---|---|---|
| START | `CH_IDLE` → `CH_RUN` | The channel's run bit is written as 1. | The divider phase is cleared. |
| HALT | `CH_RUN` → `CH_IDLE` | The channel's run bit is written as 0. | The channel stops. |

Writing a bit that equals the current state leaves the state unchanged, and the divider phase is not disturbed.

Top module: `pair_match_timer`

## Requirements
- R1: After reset, the following values hold:
  - both counters read 0;
  - both compare registers read 0xFFFF;
  - both channels are stopped;
  - both control registers read 0x0080;
  - both interrupt outputs are low.
- R2: The run register is at byte address 0. Bit n of a write moves channel n to CH_RUN (1) or CH_IDLE (0). A read returns both run bits in bits [1:0], and zeros above them.
- R3: The channel registers sit at these byte addresses:

  | Register | Channel 0 | Channel 1 |
  |---|---|---|
  | control | 2 | 8 |
  | counter | 4 | 10 |
  | compare | 6 | 12 |

  Any other address, including any odd address, reads 0, and writes to it change nothing.
- R4: The control register has the following layout:
  - bits [1:0] are the clock select;
  - bit 6 is the interrupt enable;
  - bit 7 always reads 1;
  - every other bit reads 0 and ignores writes.
- R5: A running channel advances once every 8 << (2 × clock select) clocks. Its first advance comes that many clocks after the clock edge that took the START write.
- R6: A tick that finds the count equal to the compare value has two effects. The counter becomes 0. The interrupt goes high for exactly one clock, starting on that same edge, and only if the enable bit was set. With compare C, the first pulse follows START by (C+1) × ratio clocks, and this holds for C = 0 as well.
- R7: A counter write takes effect on the next edge and overrides any count on that edge.
- R8: In CH_IDLE the counter holds its value. START restarts the divider phase from zero, whatever phase was reached before HALT.
- R9: The two channels do not interact. A stopped channel's counter and interrupt are untouched while the other channel runs, and two running channels count at their own ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for the access |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 2 | One-clock match pulse per channel |

## Verification
A wrong divider phase or a wrong clock-select decode moves the first interrupt pulse off its exact (C+1) × ratio clock slot. The bench checks that slot, and the clock before it, for every clock-select value on both channels, so the error shows within at most 1024 clocks. A counter that fails to clear at the match is visible through the bus read one clock after the pulse. A state machine stuck in the wrong state shows directly in the run register read-back, and as a counter that moves or stays frozen against the expected value.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

    // per-channel run control
    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // order of the three registers inside one channel's window
    localparam int SLOT_CTRL    = 0;
    localparam int SLOT_CNT     = 1;
    localparam int SLOT_CMP     = 2;
    localparam int REGS_PER_CH  = 3;

    // control register bit positions
    localparam int IE_BIT       = 6;
    localparam int FIXED_BIT    = 7;

    // divider ratio = 1 << (BASE_LOG2 + STEP_LOG2 * select)
    localparam int BASE_LOG2    = 3;
    localparam int STEP_LOG2    = 2;

endpackage

// File: rtl/mtp_regdec.sv
module mtp_regdec
    import mtp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 16,
    parameter int ADDR_W = 4
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NCH-1:0]    run_vec,
    input  logic [DW-1:0]     ctrl_view [NCH],
    input  logic [DW-1:0]     cnt_view  [NCH],
    input  logic [DW-1:0]     cmp_view  [NCH],
    output logic              start_we,
    output logic [NCH-1:0]    ctrl_we,
    output logic [NCH-1:0]    cnt_we,
    output logic [NCH-1:0]    cmp_we,
    output logic [DW-1:0]     bus_rdata
);

    int   slot;
    int   sel_ch;
    int   sel_fld;
    logic aligned;
    logic is_start;
    logic ch_hit;
    logic wr;

    // halfword slot 0 is the run register, then three slots per channel
    always_comb begin
        aligned  = (bus_addr[0] == 1'b0);
        slot     = int'(bus_addr[ADDR_W-1:1]);
        sel_ch   = (slot - 1) / REGS_PER_CH;
        sel_fld  = (slot - 1) % REGS_PER_CH;
        is_start = aligned && (slot == 0);
        ch_hit   = aligned && (slot != 0) && (sel_ch < NCH);
        wr       = bus_en && bus_we;
    end

    assign start_we = wr && is_start;

    for (genvar g = 0; g < NCH; g++) begin : g_strobe
        assign ctrl_we[g] = wr && ch_hit && (sel_ch == g) && (sel_fld == SLOT_CTRL);
        assign cnt_we[g]  = wr && ch_hit && (sel_ch == g) && (sel_fld == SLOT_CNT);
        assign cmp_we[g]  = wr && ch_hit && (sel_ch == g) && (sel_fld == SLOT_CMP);
    end

    always_comb begin
        bus_rdata = '0;
        if (is_start) begin
            bus_rdata[NCH-1:0] = run_vec;
        end else if (ch_hit) begin
            for (int c = 0; c < NCH; c++) begin
                if (sel_ch == c) begin
                    if (sel_fld == SLOT_CTRL)      bus_rdata = ctrl_view[c];
                    else if (sel_fld == SLOT_CNT)  bus_rdata = cnt_view[c];
                    else                           bus_rdata = cmp_view[c];
                end
            end
        end
    end

endmodule

// File: rtl/mtp_prescale.sv
module mtp_prescale
    import mtp_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int PW      = BASE_LOG2 + STEP_LOG2 * MAX_SEL;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] last;

    always_comb begin
        last = PW'((32'd1 << (BASE_LOG2 + STEP_LOG2 * int'(sel))) - 32'd1);
        // >= keeps the divider bounded if the ratio shrinks mid-period
        tick = run && (phase_q >= last);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + PW'(1);
        end
    end

endmodule

// File: rtl/mtp_channel.sv
module mtp_channel
    import mtp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SEL_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_we,
    input  logic          run_wd,
    input  logic          ctrl_we,
    input  logic          cnt_we,
    input  logic          cmp_we,
    input  logic [DW-1:0] wdata,
    output logic          running,
    output logic [DW-1:0] ctrl_rd,
    output logic [DW-1:0] cnt_rd,
    output logic [DW-1:0] cmp_rd,
    output logic          irq
);

    ch_state_e        st_q, st_d;
    logic             launch;
    logic             tick;
    logic             at_match;
    logic [SEL_W-1:0] sel_q;
    logic             ie_q;
    logic [DW-1:0]    cnt_q;
    logic [DW-1:0]    cmp_q;
    logic             irq_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // transitions: START and HALT
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_IDLE: if (run_we && run_wd)  st_d = CH_RUN;
            CH_RUN:  if (run_we && !run_wd) st_d = CH_IDLE;
            default: st_d = CH_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        running = (st_q == CH_RUN);
        launch  = (st_q == CH_IDLE) && (st_d == CH_RUN);
    end

    mtp_prescale #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .restart (launch),
        .sel     (sel_q),
        .tick    (tick)
    );

    assign at_match = (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            ie_q  <= 1'b0;
            cmp_q <= '1;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (ctrl_we) begin
                sel_q <= wdata[SEL_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end
            if (cmp_we) cmp_q <= wdata;
            if (cnt_we)     cnt_q <= wdata;
            else if (tick)  cnt_q <= at_match ? '0 : cnt_q + DW'(1);
            irq_q <= tick && at_match && ie_q;
        end
    end

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[SEL_W-1:0] = sel_q;
        ctrl_rd[IE_BIT]    = ie_q;
        ctrl_rd[FIXED_BIT] = 1'b1;
    end

    assign cnt_rd = cnt_q;
    assign cmp_rd = cmp_q;
    assign irq    = irq_q;

endmodule

// File: rtl/pair_match_timer.sv
module pair_match_timer
    import mtp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DW     = 16,
    parameter int SEL_W  = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    irq
);

    logic           start_we;
    logic [NCH-1:0] ctrl_we, cnt_we, cmp_we;
    logic [NCH-1:0] run_vec;
    logic [NCH-1:0] ie_vec;
    logic [DW-1:0]  ctrl_view [NCH];
    logic [DW-1:0]  cnt_view  [NCH];
    logic [DW-1:0]  cmp_view  [NCH];

    mtp_regdec #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_dec (
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .run_vec   (run_vec),
        .ctrl_view (ctrl_view),
        .cnt_view  (cnt_view),
        .cmp_view  (cmp_view),
        .start_we  (start_we),
        .ctrl_we   (ctrl_we),
        .cnt_we    (cnt_we),
        .cmp_we    (cmp_we),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mtp_channel #(.DW(DW), .SEL_W(SEL_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_we  (start_we),
            .run_wd  (bus_wdata[g]),
            .ctrl_we (ctrl_we[g]),
            .cnt_we  (cnt_we[g]),
            .cmp_we  (cmp_we[g]),
            .wdata   (bus_wdata),
            .running (run_vec[g]),
            .ctrl_rd (ctrl_view[g]),
            .cnt_rd  (cnt_view[g]),
            .cmp_rd  (cmp_view[g]),
            .irq     (irq[g])
        );
        assign ie_vec[g] = ctrl_view[g][IE_BIT];
    end

endmodule

// File: rtl/pair_match_timer_chk.sv
module pair_match_timer_chk #(
    parameter int NCH    = 2,
    parameter int DW     = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [NCH-1:0]    irq,
    input logic [NCH-1:0]    run,
    input logic [NCH-1:0]    ie,
    input logic [DW-1:0]     cnt0
);

    // R2
    run_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == '0) |=> (run == $past(bus_wdata[NCH-1:0])));

    // R7
    cnt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == ADDR_W'(4)) |=> (cnt0 == $past(bus_wdata)));

    for (genvar g = 0; g < NCH; g++) begin : g_irq
        // R6
        irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |=> !irq[g]);
        // R6
        irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(ie[g]));
        // R5
        irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> $past(run[g]));
    end

endmodule

bind pair_match_timer pair_match_timer_chk #(.NCH(NCH), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .run       (run_vec),
    .ie        (ie_vec),
    .cnt0      (cnt_view[0])
);

// File: tb/pair_match_timer_tb.sv
module pair_match_timer_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pair_match_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {channel, clock select, enable, compare}
    localparam logic [19:0] VEC [12] = '{
        {1'b0, 2'd0, 1'b1, 16'd3},
        {1'b0, 2'd1, 1'b1, 16'd2},
        {1'b0, 2'd2, 1'b1, 16'd1},
        {1'b0, 2'd3, 1'b1, 16'd0},
        {1'b1, 2'd0, 1'b1, 16'd0},
        {1'b1, 2'd1, 1'b1, 16'd1},
        {1'b1, 2'd2, 1'b0, 16'd2},
        {1'b1, 2'd3, 1'b1, 16'd1},
        {1'b0, 2'd0, 1'b0, 16'd0},
        {1'b1, 2'd0, 1'b1, 16'd5},
        {1'b0, 2'd2, 1'b1, 16'd0},
        {1'b1, 2'd3, 1'b1, 16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] v, oth, snap;
        logic        ch, ie;
        logic [1:0]  cks;
        logic [15:0] cmp;
        logic [3:0]  base, obase;
        int          n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  chk("R1 run", 32'(v), 32'h0);
        rd(4'd2, v);  chk("R1 ctrl0", 32'(v), 32'h0080);
        rd(4'd4, v);  chk("R1 cnt0", 32'(v), 32'h0);
        rd(4'd6, v);  chk("R1 cmp0", 32'(v), 32'hFFFF);
        rd(4'd8, v);  chk("R1 ctrl1", 32'(v), 32'h0080);
        rd(4'd10, v); chk("R1 cnt1", 32'(v), 32'h0);
        rd(4'd12, v); chk("R1 cmp1", 32'(v), 32'hFFFF);
        chk("R1 irq", 32'(irq), 32'h0);
        @(negedge clk);

        // R5 R6 R9: match timing per vector
        for (int i = 0; i < 12; i++) begin
            ch  = VEC[i][19];
            cks = VEC[i][18:17];
            ie  = VEC[i][16];
            cmp = VEC[i][15:0];
            base  = ch ? 4'd8 : 4'd2;
            obase = ch ? 4'd2 : 4'd8;
            n = (int'(cmp) + 1) * (8 << (2 * int'(cks)));
            wr(4'd0, 16'h0);
            wr(base, 16'((int'(ie) << 6) | int'(cks)));
            wr(base + 4'd4, cmp);
            wr(base + 4'd2, 16'h0);
            rd(obase + 4'd2, oth);
            @(negedge clk);
            wr(4'd0, 16'(1 << int'(ch)));
            repeat (n - 1) @(negedge clk);
            chk("R6 no early pulse", 32'(irq[ch]), 32'h0);
            rd(base + 4'd2, v);
            chk("R5 count before match", 32'(v), 32'(cmp));
            @(negedge clk);
            chk("R6 pulse at match", 32'(irq[ch]), 32'(ie));
            chk("R9 other irq quiet", 32'(irq[~ch]), 32'h0);
            rd(base + 4'd2, v);
            chk("R6 count cleared", 32'(v), 32'h0);
            @(negedge clk);
            chk("R6 pulse one cycle", 32'(irq[ch]), 32'h0);
            rd(obase + 4'd2, v);
            chk("R9 other count held", 32'(v), 32'(oth));
            @(negedge clk);
        end
        wr(4'd0, 16'h0);

        // R4 control masking
        wr(4'd2, 16'hFFFF);
        rd(4'd2, v); chk("R4 ctrl all ones", 32'(v), 32'h00C3);
        @(negedge clk);
        wr(4'd2, 16'h0000);
        rd(4'd2, v); chk("R4 ctrl zero", 32'(v), 32'h0080);
        @(negedge clk);

        // R3 unmapped and odd addresses
        rd(4'd12, snap);
        wr(4'd14, 16'h1234);
        rd(4'd14, v); chk("R3 unmapped read", 32'(v), 32'h0);
        rd(4'd12, v); chk("R3 unmapped write ignored", 32'(v), 32'(snap));
        @(negedge clk);
        rd(4'd4, snap);
        wr(4'd5, 16'hBEEF);
        rd(4'd5, v); chk("R3 odd read", 32'(v), 32'h0);
        rd(4'd4, v); chk("R3 odd write ignored", 32'(v), 32'(snap));
        @(negedge clk);

        // R2 run register
        wr(4'd0, 16'hFFFF);
        rd(4'd0, v); chk("R2 both run", 32'(v), 32'h3);
        @(negedge clk);
        wr(4'd0, 16'h0002);
        rd(4'd0, v); chk("R2 only ch1", 32'(v), 32'h2);
        @(negedge clk);
        wr(4'd0, 16'h0000);
        rd(4'd0, v); chk("R2 stopped", 32'(v), 32'h0);
        @(negedge clk);

        // R7 counter write while running
        wr(4'd2, 16'h0000);
        wr(4'd6, 16'd1000);
        wr(4'd4, 16'd0);
        wr(4'd0, 16'h0001);
        repeat (37) @(negedge clk);
        wr(4'd4, 16'd500);
        rd(4'd4, v); chk("R7 counter write", 32'(v), 32'd500);
        repeat (13) @(negedge clk);

        // R8 freeze and restart phase
        wr(4'd0, 16'h0000);
        rd(4'd4, snap);
        repeat (40) @(negedge clk);
        rd(4'd4, v); chk("R8 frozen", 32'(v), 32'(snap));
        @(negedge clk);
        wr(4'd0, 16'h0001);
        repeat (7) @(negedge clk);
        rd(4'd4, v); chk("R8 no advance before ratio", 32'(v), 32'(snap));
        @(negedge clk);
        rd(4'd4, v); chk("R8 advance at ratio", 32'(v), 32'(snap) + 32'd1);
        @(negedge clk);
        wr(4'd0, 16'h0000);

        // R9 two channels at different ratios
        wr(4'd2, 16'h0000); wr(4'd6, 16'hFFFF); wr(4'd4, 16'h0);
        wr(4'd8, 16'h0001); wr(4'd12, 16'hFFFF); wr(4'd10, 16'h0);
        wr(4'd0, 16'h0003);
        repeat (64) @(negedge clk);
        rd(4'd4, v);  chk("R9 ch0 count", 32'(v), 32'd8);
        rd(4'd10, v); chk("R9 ch1 count", 32'(v), 32'd2);
        @(negedge clk);
        wr(4'd0, 16'h0000);

        summary();
    end

endmodule